// File: doc/BRIEF.md
# Multiplexed Bus Target Responder

This block is the target side of a shared, multiplexed address/data bus with active-low handshakes. In the address phase it compares the bus word with a base register held in a small configuration space. If the cycle falls inside its window, it claims the cycle one clock later. It then paces each data phase with its ready line. It can also end the cycle early with a halt line, using one of four termination styles.

Memory and I/O accesses are refused until a configuration write has loaded the base register. Writes are passed to a simple local port as an offset inside the window, a strobe, data and active-high byte enables. Read data comes back from the local port with a valid flag. For reads the target drives an even parity bit one clock after the data. For writes it checks the parity bit the initiator sends one clock after the data.

A test control input picks the termination style for the next claimed cycle: normal completion, retry, disconnect with one more data phase, disconnect with no more data, or target abort.

Top module: `bus_target_responder`

## Requirements
- R1: When `cyc_n` falls while the target is idle, the target claims the cycle if the command is a memory/I/O code and the address masked to its upper DW-WIN_BITS bits equals the base register. It also claims when `cfg_sel` is high with a configuration code. A claim drives `claim_n` low after the next rising edge. Addresses outside the window are not claimed.
- R2: Memory and I/O commands are never claimed until a configuration write to offset 0x10 has loaded the base register. The low WIN_BITS bits of the written value are cleared.
- R3: For a write in normal mode, `tgt_rdy_n` goes low together with `claim_n`. A word moves only on an edge where both `tgt_rdy_n` and `ini_rdy_n` are low. After each moved word, `tgt_rdy_n` is high for exactly one cycle.
- R4: While `ini_rdy_n` is high, no word moves, `lcl_we` stays low and `tgt_rdy_n` keeps its value.
- R5: With `term_sel`=1 (retry), the claim cycle shows `claim_n`=0, `halt_n`=0 and `tgt_rdy_n`=1, and no word moves.
- R6: With `term_sel`=2 (disconnect with data), `halt_n` falls together with the first `tgt_rdy_n`. Exactly one word moves, then `tgt_rdy_n` rises while `halt_n` and `claim_n` stay low.
- R7: With `term_sel`=3 (disconnect without data), the first word moves. On that same edge `halt_n` falls and `tgt_rdy_n` rises, and no later word moves.
- R8: With `term_sel`=4 (target abort), on the edge after the claim `halt_n` falls while `claim_n` and `tgt_rdy_n` both go high.
- R9: Once `halt_n` is low it stays low until `cyc_n` is sampled high. On that edge `claim_n`, `tgt_rdy_n`, `halt_n` and `bus_oe` all return to their inactive values. The same idle values hold after reset.
- R10: During a memory/I/O write transfer, `lcl_we` is high in the transfer cycle. `lcl_addr` is the address minus the base register, and it advances by 4 per word. `lcl_wdata` carries the bus word and `lcl_be` is the inverse of `cmd_be_n`.
- R11: For a read, after `lcl_rvalid` is seen the next edge puts the data on `bus_out` with `tgt_rdy_n` low. One edge after the transfer, `pbit_out` equals the XOR of that data word and `cmd_be_n`.
- R12: One edge after a write transfer, `pbit_in` is compared with the XOR of the transferred word and its `cmd_be_n`. On a mismatch, `par_err_n` is low for the following cycle and the target aborts on that same edge (R8 pin shape).
- R13: Command codes: 0x2/0x3 are I/O read/write, 0x6/0x7 are memory read/write, 0xA/0xB are configuration read/write (only with `cfg_sel`=1). All other codes are ignored. A configuration read at offset 0x10 returns the base register. Configuration writes never pulse `lcl_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_n | input | 1 | Initiator cycle active, low |
| bus_in | input | DW | Multiplexed address/data from the bus |
| bus_out | output | DW | Read data driven by the target |
| bus_oe | output | 1 | Target drives bus_out |
| cmd_be_n | input | DW/8 | Command in address phase, byte enables (low) in data phase |
| pbit_in | input | 1 | Parity bit from the initiator |
| pbit_out | output | 1 | Parity bit from the target |
| pbit_oe | output | 1 | Target drives pbit_out |
| cfg_sel | input | 1 | Selects this target for configuration cycles |
| ini_rdy_n | input | 1 | Initiator ready, low |
| tgt_rdy_n | output | 1 | Target ready, low |
| claim_n | output | 1 | Target has claimed the cycle, low |
| halt_n | output | 1 | Target requests termination, low |
| par_err_n | output | 1 | Write data parity error, low |
| term_sel | input | 3 | Termination style for the next claimed cycle |
| lcl_addr | output | WIN_BITS | Offset within the window |
| lcl_we | output | 1 | Local write strobe |
| lcl_wdata | output | DW | Local write data |
| lcl_be | output | DW/8 | Local byte enables, high |
| lcl_rvalid | input | 1 | Local read data valid |
| lcl_rdata | input | DW | Local read data |

## Verification
The bench targets the gate before configuration. A design that skipped it would claim a memory write while the base register is still zero. It checks window edges just above and below the decoded range and reserved command codes; a loose compare or decode would claim those. Each termination style is checked cycle by cycle. A design that mixed up the order of the ready and halt edges would move a second word after a disconnect, or keep `claim_n` low through an abort. A deliberately wrong parity bit must raise `par_err_n` exactly two edges after the word and abort the cycle; an off-by-one pipeline would flag the wrong cycle or keep accepting data.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    typedef enum logic [2:0] {
        TERM_NONE        = 3'd0,
        TERM_RETRY       = 3'd1,
        TERM_DISC_DATA   = 3'd2,
        TERM_DISC_NODATA = 3'd3,
        TERM_ABORT       = 3'd4
    } term_e;

    typedef enum logic {
        ST_IDLE,
        ST_DATA
    } state_e;

    typedef struct packed {
        logic  is_wr;
        logic  is_cfg;
        term_e mode;
    } xact_t;

    function automatic logic cmd_is_space(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR) ||
               (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

    function automatic logic cmd_is_cfg(input logic [3:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
    endfunction

    function automatic term_e to_mode(input logic [2:0] s);
        case (s)
            3'd1:    return TERM_RETRY;
            3'd2:    return TERM_DISC_DATA;
            3'd3:    return TERM_DISC_NODATA;
            3'd4:    return TERM_ABORT;
            default: return TERM_NONE;
        endcase
    endfunction

    // ready at claim only for writes that will accept a first word
    function automatic logic ready_at_claim(input logic wr, input term_e m);
        return wr && (m == TERM_NONE || m == TERM_DISC_DATA || m == TERM_DISC_NODATA);
    endfunction

endpackage

// File: rtl/tgt_cfg_decode.sv
module tgt_cfg_decode
    import tgt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int WIN_BITS = 8,
    parameter int BAR_OFS  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DW-1:0]       ad_in,
    input  logic [3:0]          cmd_in,
    input  logic                cfg_sel,
    input  logic                wr_en,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [DW-1:0]       wr_data,
    output logic                claim_hit,
    output logic                claim_cfg,
    output logic                enabled,
    output logic [DW-1:0]       rd_data
);

    localparam logic [DW-1:0]       WIN_MASK = {{(DW-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};
    localparam logic [WIN_BITS-1:0] BAR_SLOT = WIN_BITS'(BAR_OFS);

    logic [DW-1:0] bar_q;
    logic          space_hit;

    always_comb begin
        claim_cfg = cfg_sel && cmd_is_cfg(cmd_in);
        space_hit = enabled && cmd_is_space(cmd_in) && ((ad_in & WIN_MASK) == bar_q);
        claim_hit = claim_cfg || space_hit;
        rd_data   = (ofs == BAR_SLOT) ? bar_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q   <= '0;
            enabled <= 1'b0;
        end else if (wr_en && ofs == BAR_SLOT) begin
            bar_q   <= wr_data & WIN_MASK;
            enabled <= 1'b1;
        end
    end

    // R2: once enabled the target stays enabled
    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (rst)
        enabled |=> enabled);

    // R2: enabling only follows a configuration write
    a_r2_enable_source: assert property (@(posedge clk) disable iff (rst)
        $rose(enabled) |-> $past(wr_en));

endmodule

// File: rtl/tgt_parity.sv
module tgt_parity #(
    parameter int DW   = 32,
    parameter int BE_W = DW/8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   drv_data,
    input  logic            drv_oe,
    input  logic [BE_W-1:0] be_n,
    input  logic            chk_en,
    input  logic [DW-1:0]   ad_in,
    input  logic            pbit_in,
    output logic            pbit_out,
    output logic            pbit_oe,
    output logic            par_bad,
    output logic            par_err_n
);

    logic chk_pend;
    logic chk_bit;

    assign par_bad = chk_pend && (chk_bit != pbit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            pbit_out  <= 1'b0;
            pbit_oe   <= 1'b0;
            chk_pend  <= 1'b0;
            chk_bit   <= 1'b0;
            par_err_n <= 1'b1;
        end else begin
            pbit_out  <= ^{drv_data, be_n};
            pbit_oe   <= drv_oe;
            chk_pend  <= chk_en;
            chk_bit   <= ^{ad_in, be_n};
            par_err_n <= !par_bad;
        end
    end

    // R12: an error flag can only follow a checked write two edges back
    a_r12_perr_timing: assert property (@(posedge clk) disable iff (rst)
        $fell(par_err_n) |-> $past(chk_en, 2));

endmodule

// File: rtl/bus_target_responder.sv
module bus_target_responder
    import tgt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int WIN_BITS = 8,
    parameter int BAR_OFS  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cyc_n,
    input  logic [DW-1:0]       bus_in,
    output logic [DW-1:0]       bus_out,
    output logic                bus_oe,
    input  logic [DW/8-1:0]     cmd_be_n,
    input  logic                pbit_in,
    output logic                pbit_out,
    output logic                pbit_oe,
    input  logic                cfg_sel,
    input  logic                ini_rdy_n,
    output logic                tgt_rdy_n,
    output logic                claim_n,
    output logic                halt_n,
    output logic                par_err_n,
    input  logic [2:0]          term_sel,
    output logic [WIN_BITS-1:0] lcl_addr,
    output logic                lcl_we,
    output logic [DW-1:0]       lcl_wdata,
    output logic [DW/8-1:0]     lcl_be,
    input  logic                lcl_rvalid,
    input  logic [DW-1:0]       lcl_rdata
);

    localparam int                  BE_W = DW/8;
    localparam logic [WIN_BITS-1:0] STEP = WIN_BITS'(BE_W);

    state_e              state;
    xact_t               xq;
    logic [WIN_BITS-1:0] ofs_q;
    logic                cyc_prev_n;
    logic [DW-1:0]       drv_q;

    logic          claim_hit, claim_cfg, cfg_enabled;
    logic [DW-1:0] cfg_rd;
    logic          par_bad;
    logic          addr_phase, xfer, finish, cfg_we, chk_en;
    logic          src_valid;
    logic [DW-1:0] src_data;
    term_e         new_mode;

    always_comb begin
        new_mode   = to_mode(term_sel);
        addr_phase = (state == ST_IDLE) && !cyc_n && cyc_prev_n;
        xfer       = (state == ST_DATA) && !tgt_rdy_n && !ini_rdy_n;
        finish     = cyc_n && (xfer || !halt_n);
        cfg_we     = xfer && xq.is_wr && xq.is_cfg;
        chk_en     = xfer && xq.is_wr;
        src_valid  = xq.is_cfg ? 1'b1 : lcl_rvalid;
        src_data   = xq.is_cfg ? cfg_rd : lcl_rdata;
        lcl_we     = xfer && xq.is_wr && !xq.is_cfg;
        lcl_addr   = ofs_q;
        lcl_wdata  = bus_in;
        lcl_be     = ~cmd_be_n;
        bus_out    = drv_q;
    end

    tgt_cfg_decode #(.DW(DW), .WIN_BITS(WIN_BITS), .BAR_OFS(BAR_OFS)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .ad_in    (bus_in),
        .cmd_in   (cmd_be_n[3:0]),
        .cfg_sel  (cfg_sel),
        .wr_en    (cfg_we),
        .ofs      (ofs_q),
        .wr_data  (bus_in),
        .claim_hit(claim_hit),
        .claim_cfg(claim_cfg),
        .enabled  (cfg_enabled),
        .rd_data  (cfg_rd)
    );

    tgt_parity #(.DW(DW), .BE_W(BE_W)) u_par (
        .clk      (clk),
        .rst      (rst),
        .drv_data (drv_q),
        .drv_oe   (bus_oe),
        .be_n     (cmd_be_n),
        .chk_en   (chk_en),
        .ad_in    (bus_in),
        .pbit_in  (pbit_in),
        .pbit_out (pbit_out),
        .pbit_oe  (pbit_oe),
        .par_bad  (par_bad),
        .par_err_n(par_err_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            xq         <= '{is_wr: 1'b0, is_cfg: 1'b0, mode: TERM_NONE};
            ofs_q      <= '0;
            cyc_prev_n <= 1'b1;
            drv_q      <= '0;
            claim_n    <= 1'b1;
            tgt_rdy_n  <= 1'b1;
            halt_n     <= 1'b1;
            bus_oe     <= 1'b0;
        end else begin
            cyc_prev_n <= cyc_n;
            case (state)
                ST_IDLE: begin
                    if (addr_phase && claim_hit) begin
                        state     <= ST_DATA;
                        xq.is_wr  <= cmd_be_n[0];
                        xq.is_cfg <= claim_cfg;
                        xq.mode   <= new_mode;
                        ofs_q     <= bus_in[WIN_BITS-1:0];
                        claim_n   <= 1'b0;
                        tgt_rdy_n <= !ready_at_claim(cmd_be_n[0], new_mode);
                        halt_n    <= !(new_mode == TERM_RETRY ||
                                       (new_mode == TERM_DISC_DATA && cmd_be_n[0]));
                        bus_oe    <= !cmd_be_n[0];
                    end
                end
                ST_DATA: begin
                    if (finish) begin
                        state     <= ST_IDLE;
                        claim_n   <= 1'b1;
                        tgt_rdy_n <= 1'b1;
                        halt_n    <= 1'b1;
                        bus_oe    <= 1'b0;
                    end else if ((xq.mode == TERM_ABORT && halt_n) || par_bad) begin
                        claim_n   <= 1'b1;
                        tgt_rdy_n <= 1'b1;
                        halt_n    <= 1'b0;
                    end else if (xfer) begin
                        ofs_q     <= ofs_q + STEP;
                        tgt_rdy_n <= 1'b1;
                        if (xq.mode == TERM_DISC_NODATA) halt_n <= 1'b0;
                    end else if (tgt_rdy_n && halt_n && xq.mode != TERM_ABORT) begin
                        if (xq.is_wr) begin
                            tgt_rdy_n <= 1'b0;
                        end else if (src_valid) begin
                            drv_q     <= src_data;
                            tgt_rdy_n <= 1'b0;
                            if (xq.mode == TERM_DISC_DATA) halt_n <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a decoded hit in the address phase claims on the next edge
    a_r1_claim_next: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && claim_hit) |=> !claim_n);

    // R8: halt without claim means ready is released too
    a_r8_abort_shape: assert property (@(posedge clk) disable iff (rst)
        (!halt_n && claim_n) |-> tgt_rdy_n);

    // R6: ready and halt low together only in disconnect-with-data
    a_r6_ready_with_halt: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && !halt_n) |-> (xq.mode == TERM_DISC_DATA));

    // R7: no local write once halt is showing, except the one allowed phase
    a_r7_no_late_word: assert property (@(posedge clk) disable iff (rst)
        (lcl_we && !halt_n) |-> (xq.mode == TERM_DISC_DATA));

    // R9: halt seen with cycle ended releases every control line
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !halt_n && cyc_n) |=> (halt_n && claim_n && tgt_rdy_n && !bus_oe));

    // R2: local writes only after configuration
    a_r2_gate: assert property (@(posedge clk) disable iff (rst)
        lcl_we |-> cfg_enabled);

    // R4: initiator wait holds ready and offset
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && ini_rdy_n && !cyc_n && !tgt_rdy_n && !par_bad &&
         xq.mode != TERM_ABORT) |=> (!tgt_rdy_n && $stable(ofs_q)));

endmodule

// File: tb/tb_bus_target_responder.sv
module tb_bus_target_responder;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h12345600;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_n, pbit_in, cfg_sel, ini_rdy_n, lcl_rvalid;
    logic [31:0] bus_in;
    logic [3:0]  cmd_be_n;
    logic [2:0]  term_sel;
    logic [31:0] bus_out, lcl_wdata, lcl_rdata;
    logic        bus_oe, pbit_out, pbit_oe, tgt_rdy_n, claim_n, halt_n, par_err_n, lcl_we;
    logic [7:0]  lcl_addr;
    logic [3:0]  lcl_be;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign lcl_rdata = 32'hBEEF0000 | {24'h0, lcl_addr};

    bus_target_responder dut (
        .clk(clk), .rst(rst), .cyc_n(cyc_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .cmd_be_n(cmd_be_n), .pbit_in(pbit_in), .pbit_out(pbit_out),
        .pbit_oe(pbit_oe), .cfg_sel(cfg_sel), .ini_rdy_n(ini_rdy_n), .tgt_rdy_n(tgt_rdy_n),
        .claim_n(claim_n), .halt_n(halt_n), .par_err_n(par_err_n), .term_sel(term_sel),
        .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata), .lcl_be(lcl_be),
        .lcl_rvalid(lcl_rvalid), .lcl_rdata(lcl_rdata)
    );

    // {cmd, cfg_sel, expect claim, address}
    localparam logic [37:0] VEC [10] = '{
        {4'h7, 1'b0, 1'b1, 32'h12345604},
        {4'h6, 1'b0, 1'b1, 32'h123456F0},
        {4'h3, 1'b0, 1'b1, 32'h12345610},
        {4'h2, 1'b0, 1'b1, 32'h123456FC},
        {4'h7, 1'b0, 1'b0, 32'h12345700},
        {4'h7, 1'b0, 1'b0, 32'h123455FC},
        {4'h4, 1'b0, 1'b0, 32'h12345608},
        {4'hC, 1'b0, 1'b0, 32'h12345608},
        {4'hB, 1'b0, 1'b0, 32'h00000010},
        {4'hA, 1'b1, 1'b1, 32'h00000010}
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle;
        cyc_n = 1'b1; ini_rdy_n = 1'b1; cfg_sel = 1'b0;
        bus_in = '0; cmd_be_n = 4'h0; pbit_in = 1'b0;
    endtask

    task automatic addr(input logic [3:0] c, input logic [31:0] a, input logic cs, input logic [2:0] m);
        cyc_n = 1'b0; bus_in = a; cmd_be_n = c; cfg_sel = cs; term_sel = m;
        tick;
        cfg_sel = 1'b0;
    endtask

    task automatic data(input logic [31:0] d, input logic last);
        bus_in = d; cmd_be_n = 4'h0; ini_rdy_n = 1'b0; cyc_n = last;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; term_sel = 3'd0; lcl_rvalid = 1'b1;
        go_idle;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        // R9: idle values after reset
        chk("R9 reset claim_n", claim_n, 1);
        chk("R9 reset tgt_rdy_n", tgt_rdy_n, 1);
        chk("R9 reset halt_n", halt_n, 1);
        chk("R9 reset bus_oe", bus_oe, 0);
        chk("R12 reset par_err_n", par_err_n, 1);

        // R2: no claim before configuration
        addr(4'h7, 32'h00000008, 1'b0, 3'd0);
        chk("R2 unconfigured zero base", claim_n, 1);
        go_idle; tick;
        addr(4'h7, BASE + 8, 1'b0, 3'd0);
        chk("R2 unconfigured window", claim_n, 1);
        go_idle; tick;

        // R13/R2: configuration write of base at 0x10
        addr(4'hB, 32'h10, 1'b1, 3'd0);
        chk("R13 cfg write claim", claim_n, 0);
        data(32'h12345678, 1'b1);
        chk("R13 cfg write no lcl_we", lcl_we, 0);
        tick;
        pbit_in = ^{32'h12345678, 4'h0}; ini_rdy_n = 1'b1;
        tick;
        go_idle; tick;

        // R13/R11: configuration read returns masked base
        addr(4'hA, 32'h10, 1'b1, 3'd0);
        data(32'h0, 1'b1);
        tick;
        chk("R13 cfg read data", bus_out, BASE);
        chk("R11 cfg read ready", tgt_rdy_n, 0);
        tick;
        chk("R11 cfg read parity", pbit_out, ^{BASE, 4'h0});
        chk("R9 cfg read released", claim_n, 1);
        go_idle; tick;

        // Table walk: decode and claim (R1, R13)
        foreach (VEC[i]) begin
            addr(VEC[i][37:34], VEC[i][31:0], VEC[i][33], 3'd0);
            chk($sformatf("R1 R13 vec%0d claim", i), claim_n, !VEC[i][32]);
            data(32'h0, 1'b1);
            for (int k = 0; k < 6 && !claim_n; k++) tick;
            chk($sformatf("R9 vec%0d end", i), claim_n, 1);
            go_idle; tick; tick;
        end

        // R3/R4/R10/R12: two-word write with initiator wait
        addr(4'h7, BASE + 8, 1'b0, 3'd0);
        chk("R3 claim ready", tgt_rdy_n, 0);
        ini_rdy_n = 1'b1; bus_in = 32'h11112222; #1;
        chk("R4 no write while waiting", lcl_we, 0);
        tick;
        chk("R4 ready held", tgt_rdy_n, 0);
        data(32'hA1B2C3D4, 1'b0);
        chk("R10 we", lcl_we, 1);
        chk("R10 addr", lcl_addr, 8'h08);
        chk("R10 wdata", lcl_wdata, 32'hA1B2C3D4);
        chk("R10 be", lcl_be, 4'hF);
        tick;
        chk("R3 wait after word", tgt_rdy_n, 1);
        pbit_in = ^{32'hA1B2C3D4, 4'h0};
        data(32'h55667788, 1'b1);
        chk("R3 no move while not ready", lcl_we, 0);
        tick;
        chk("R3 rearm", tgt_rdy_n, 0);
        #1;
        chk("R10 second addr", lcl_addr, 8'h0C);
        chk("R10 second we", lcl_we, 1);
        tick;
        chk("R9 normal end", claim_n, 1);
        pbit_in = ^{32'h55667788, 4'h0}; ini_rdy_n = 1'b1;
        tick;
        chk("R12 good parity", par_err_n, 1);
        go_idle; tick;

        // R11: read with delayed local data
        lcl_rvalid = 1'b0;
        addr(4'h6, BASE + 32'h20, 1'b0, 3'd0);
        data(32'h0, 1'b0);
        tick;
        chk("R11 waits for rvalid", tgt_rdy_n, 1);
        lcl_rvalid = 1'b1;
        tick;
        chk("R11 read data", bus_out, 32'hBEEF0020);
        chk("R11 read ready", tgt_rdy_n, 0);
        chk("R11 bus_oe", bus_oe, 1);
        cyc_n = 1'b1;
        tick;
        chk("R11 read parity", pbit_out, ^{32'hBEEF0020, 4'h0});
        chk("R9 read released oe", bus_oe, 0);
        go_idle; tick;

        // R5: retry
        addr(4'h7, BASE + 4, 1'b0, 3'd1);
        chk("R5 claim", claim_n, 0);
        chk("R5 halt", halt_n, 0);
        chk("R5 not ready", tgt_rdy_n, 1);
        data(32'hDEAD0001, 1'b1);
        chk("R5 no transfer", lcl_we, 0);
        tick;
        chk("R9 retry release halt", halt_n, 1);
        chk("R9 retry release claim", claim_n, 1);
        go_idle; tick;

        // R6: disconnect with data
        addr(4'h7, BASE + 4, 1'b0, 3'd2);
        chk("R6 halt with ready", {halt_n, tgt_rdy_n, claim_n}, 3'b000);
        data(32'hCAFE0001, 1'b0);
        chk("R6 one word", lcl_we, 1);
        tick;
        chk("R6 after word", {halt_n, tgt_rdy_n, claim_n}, 3'b010);
        pbit_in = ^{32'hCAFE0001, 4'h0};
        data(32'hCAFE0002, 1'b0);
        chk("R6 no second word", lcl_we, 0);
        tick;
        chk("R9 halt held while cycle on", halt_n, 0);
        cyc_n = 1'b1; #1;
        chk("R6 no word at end", lcl_we, 0);
        tick;
        chk("R9 disc release", {halt_n, tgt_rdy_n, claim_n}, 3'b111);
        go_idle; tick;

        // R7: disconnect without data
        addr(4'h7, BASE + 4, 1'b0, 3'd3);
        chk("R7 claim shape", {halt_n, tgt_rdy_n, claim_n}, 3'b100);
        data(32'hF00D0001, 1'b0);
        chk("R7 first word", lcl_we, 1);
        tick;
        chk("R7 halt and drop ready", {halt_n, tgt_rdy_n, claim_n}, 3'b010);
        pbit_in = ^{32'hF00D0001, 4'h0};
        data(32'hF00D0002, 1'b1);
        chk("R7 no more data", lcl_we, 0);
        tick;
        chk("R9 nodata release", {halt_n, tgt_rdy_n, claim_n}, 3'b111);
        go_idle; tick;

        // R8: target abort
        addr(4'h7, BASE + 4, 1'b0, 3'd4);
        chk("R8 claim", {halt_n, claim_n}, 2'b10);
        data(32'h0BAD0001, 1'b0);
        chk("R8 no transfer", lcl_we, 0);
        tick;
        chk("R8 abort shape", {halt_n, tgt_rdy_n, claim_n}, 3'b011);
        cyc_n = 1'b1; ini_rdy_n = 1'b1;
        tick;
        chk("R9 abort release", halt_n, 1);
        go_idle; tick;

        // R12: parity error ends in abort
        addr(4'h7, BASE + 4, 1'b0, 3'd0);
        data(32'h13579BDF, 1'b0);
        tick;
        pbit_in = ~(^{32'h13579BDF, 4'h0});
        data(32'h2468ACE0, 1'b0);
        chk("R12 no word in check cycle", lcl_we, 0);
        tick;
        chk("R12 perr low", par_err_n, 0);
        chk("R12 abort shape", {halt_n, tgt_rdy_n, claim_n}, 3'b011);
        cyc_n = 1'b1; ini_rdy_n = 1'b1;
        tick;
        chk("R12 perr one cycle", par_err_n, 1);
        chk("R9 parity abort release", halt_n, 1);
        go_idle; tick;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule